// File: doc/BRIEF.md
# Strobed Byte FIFO Host Controller

This block is the host side of a link to an external byte FIFO device that has no clock of its own. The device shares one 8-bit data bus between both directions. It is driven by two active-low strobes: one for reads and one for writes. It reports its state on two active-low flags: one says a received byte is waiting, the other says the transmit side has room. The controller synchronises both flags into the system clock. It performs one transfer at a time, shapes each strobe from cycle counts set by parameters, and controls the bus through a separate output-enable pin.

On the local side there are two valid/ready byte streams:

- **Transmit stream (in).** `tx_ready` depends only on the controller's own state and the synchronised space flag, never on `tx_valid`. A byte is taken on a clock edge where both are high. A source may hold `tx_valid` high for as long as it likes without losing the byte.
- **Receive stream (out).** Once `rx_valid` is raised, it and `rx_data` stay fixed until a clock edge where `rx_ready` is high. While a byte is waiting there, no new read is started. Back-pressure on the receive stream therefore holds off the device instead of dropping data.

Strobe shaping uses three parameters, each counted in system clock cycles with a minimum of 2:

- `STROBE_CYC` sets how long either strobe stays low.
- `SETUP_CYC` sets how long write data is driven before the write strobe falls.
- `GAP_CYC` sets the idle time after any strobe, which gives the device's flags time to settle before they are looked at again.

Top module: `pfifo_host_ctrl`

## Requirements
- R1: After reset, `rd_n` and `wr_n` are high, `bus_oe` is low and `rx_valid` is low.
- R2: A read starts only when the synchronised `dav_n` is low and no received byte is waiting on the receive stream. `rd_n` then stays low for exactly `STROBE_CYC` cycles.
- R3: The byte on `bus_din` at the last clock edge of the `rd_n` low time is presented on `rx_data` with `rx_valid`. It is held stable until accepted, and bytes come out in the order the device supplied them.
- R4: An accepted transmit byte is driven on `bus_dout` with `bus_oe` high for exactly `SETUP_CYC` cycles while `wr_n` is high. `wr_n` is then low for exactly `STROBE_CYC` cycles with the same byte still driven. `bus_oe` falls when `wr_n` rises.
- R5: While the synchronised `spc_n` is high, `tx_ready` stays low and no write strobe occurs. A byte held on the transmit stream goes out once `spc_n` goes low.
- R6: When a read and a write both become permitted at the same time, the read strobe is issued first.
- R7: `rd_n` and `wr_n` are never low together, and `bus_oe` is never high while `rd_n` is low.
- R8: Between the rise of one strobe and the next strobe fall or bus drive, both strobes are high and the bus is released for at least `GAP_CYC` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_valid | input | 1 | Transmit stream byte valid |
| tx_ready | output | 1 | Transmit stream ready |
| tx_data | input | 8 | Transmit stream byte |
| rx_valid | output | 1 | Receive stream byte valid |
| rx_ready | input | 1 | Receive stream ready |
| rx_data | output | 8 | Receive stream byte |
| bus_din | input | 8 | Data bus as seen at the pins |
| bus_dout | output | 8 | Data driven onto the bus during writes |
| bus_oe | output | 1 | Bus driver enable, high during write setup and strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| dav_n | input | 1 | Device flag, low when a received byte is waiting (asynchronous) |
| spc_n | input | 1 | Device flag, low when a byte may be written (asynchronous) |

## Verification
A sequencer stuck in or skipping a state shows at the pins within one transfer. The measured strobe width, setup time or gap comes out wrong, or both strobes are seen low together, on the very cycle the strobe edges move.

A broken capture stage, or a wrong flag gate, shows as a byte that differs from, is missing from, or is repeated in the scoreboard order. The receive side shows this when the byte is handed over. The transmit side shows it at the device's write strobe fall.

A flag gate that ignores `spc_n`, or ignores a full receive stage, causes a strobe during a hold window that should stay quiet. That strobe is counted at once.

// File: rtl/pfh_pkg.sv
package pfh_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_SETUP = 3'd2,
    ST_WLOW  = 3'd3,
    ST_GAP   = 3'd4
  } seq_state_t;
endpackage

// File: rtl/pfh_flag_sync.sv
module pfh_flag_sync #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  // flags are active low: reset to the inactive (high) level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '1;
      stage2_q <= '1;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/pfh_rx_stage.sv
module pfh_rx_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [DW-1:0] cap_data,
  output logic          slot_free,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic [DW-1:0] rx_data
);
  logic          vld_q;
  logic [DW-1:0] dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (cap_en) begin
      vld_q <= 1'b1;
      dat_q <= cap_data;
    end else if (vld_q && rx_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign rx_valid  = vld_q;
  assign rx_data   = dat_q;
  assign slot_free = !vld_q;
endmodule

// File: rtl/pfh_seq.sv
module pfh_seq
  import pfh_pkg::*;
#(
  parameter int DW         = 8,
  parameter int STROBE_CYC = 3,
  parameter int SETUP_CYC  = 2,
  parameter int GAP_CYC    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dav_ok,
  input  logic          spc_ok,
  input  logic          slot_free,
  input  logic          tx_valid,
  input  logic [DW-1:0] tx_data,
  output logic          tx_ready,
  output logic          rd_n,
  output logic          wr_n,
  output logic          bus_oe,
  output logic [DW-1:0] wdata,
  output logic          cap_en
);
  localparam int MAXC = (STROBE_CYC > SETUP_CYC) ?
                        ((STROBE_CYC > GAP_CYC) ? STROBE_CYC : GAP_CYC) :
                        ((SETUP_CYC > GAP_CYC) ? SETUP_CYC : GAP_CYC);
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] STB_LD = CW'(STROBE_CYC - 1);
  localparam logic [CW-1:0] SET_LD = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] GAP_LD = CW'(GAP_CYC - 1);

  seq_state_t    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rd_n_q, wr_n_q, oe_q;
  logic [DW-1:0] wdata_q;
  logic          read_go, write_go, cnt_done;

  assign cnt_done = (cnt_q == '0);
  // a read wins whenever one is permitted in the idle state
  assign read_go  = (st_q == ST_IDLE) && dav_ok && slot_free;
  assign tx_ready = (st_q == ST_IDLE) && spc_ok && !read_go;
  assign write_go = tx_ready && tx_valid;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cap_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (read_go) begin
          st_d  = ST_READ;
          cnt_d = STB_LD;
        end else if (write_go) begin
          st_d  = ST_SETUP;
          cnt_d = SET_LD;
        end
      end
      ST_READ: begin
        if (cnt_done) begin
          cap_en = 1'b1;
          st_d   = ST_GAP;
          cnt_d  = GAP_LD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_SETUP: begin
        if (cnt_done) begin
          st_d  = ST_WLOW;
          cnt_d = STB_LD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_WLOW: begin
        if (cnt_done) begin
          st_d  = ST_GAP;
          cnt_d = GAP_LD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_GAP: begin
        if (cnt_done) st_d = ST_IDLE;
        else          cnt_d = cnt_q - 1'b1;
      end
      default: begin
        st_d  = ST_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  // pin levels come from flops loaded with the next state decode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      rd_n_q  <= 1'b1;
      wr_n_q  <= 1'b1;
      oe_q    <= 1'b0;
      wdata_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      rd_n_q <= (st_d != ST_READ);
      wr_n_q <= (st_d != ST_WLOW);
      oe_q   <= (st_d == ST_SETUP) || (st_d == ST_WLOW);
      if (write_go) wdata_q <= tx_data;
    end
  end

  assign rd_n   = rd_n_q;
  assign wr_n   = wr_n_q;
  assign bus_oe = oe_q;
  assign wdata  = wdata_q;
endmodule

// File: rtl/pfifo_host_ctrl.sv
module pfifo_host_ctrl #(
  parameter int DW         = 8,
  parameter int STROBE_CYC = 3,
  parameter int SETUP_CYC  = 2,
  parameter int GAP_CYC    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic [DW-1:0] tx_data,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic [DW-1:0] rx_data,
  input  logic [DW-1:0] bus_din,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe,
  output logic          rd_n,
  output logic          wr_n,
  input  logic          dav_n,
  input  logic          spc_n
);
  localparam int NFLAG = 2;

  initial begin
    if (STROBE_CYC < 2 || SETUP_CYC < 2 || GAP_CYC < 2)
      $error("cycle-count parameters must be at least 2");
  end

  logic [NFLAG-1:0] flags_sync;
  logic             slot_free, cap_en;

  pfh_flag_sync #(.WIDTH(NFLAG)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({spc_n, dav_n}),
    .sync_out (flags_sync)
  );

  pfh_seq #(
    .DW(DW), .STROBE_CYC(STROBE_CYC), .SETUP_CYC(SETUP_CYC), .GAP_CYC(GAP_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .dav_ok    (!flags_sync[0]),
    .spc_ok    (!flags_sync[1]),
    .slot_free (slot_free),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_ready  (tx_ready),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .bus_oe    (bus_oe),
    .wdata     (bus_dout),
    .cap_en    (cap_en)
  );

  pfh_rx_stage #(.DW(DW)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_en    (cap_en),
    .cap_data  (bus_din),
    .slot_free (slot_free),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .rx_data   (rx_data)
  );
endmodule

// File: rtl/pfh_checker.sv
module pfh_checker #(
  parameter int DW         = 8,
  parameter int STROBE_CYC = 3,
  parameter int SETUP_CYC  = 2,
  parameter int GAP_CYC    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_n,
  input logic          wr_n,
  input logic          bus_oe,
  input logic [DW-1:0] bus_dout,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic [DW-1:0] rx_data,
  input logic          tx_ready
);
  localparam int LIM = 1 << 15;
  int unsigned rd_len, wr_len, setup_len, gap_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_len    <= 0;
      wr_len    <= 0;
      setup_len <= 0;
      gap_len   <= LIM;
    end else begin
      rd_len    <= !rd_n ? rd_len + 1 : 0;
      wr_len    <= !wr_n ? wr_len + 1 : 0;
      setup_len <= (bus_oe && wr_n) ? setup_len + 1 : 0;
      gap_len   <= (rd_n && wr_n && !bus_oe) ?
                   ((gap_len < LIM) ? gap_len + 1 : gap_len) : 0;
    end
  end

  a_r1_idle_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> rd_n && wr_n && !bus_oe && !rx_valid);

  a_r2_read_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |-> rd_len == STROBE_CYC);

  a_r3_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));

  a_r4_setup_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |-> setup_len == SETUP_CYC && bus_oe);

  a_r4_write_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> wr_len == STROBE_CYC && !bus_oe);

  a_r4_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe && $past(bus_oe) |-> $stable(bus_dout));

  a_r5_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> rd_n && wr_n && !bus_oe);

  a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  a_r7_no_drive_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !bus_oe);

  a_r8_gap_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |-> gap_len >= GAP_CYC);

  a_r8_gap_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |-> gap_len >= GAP_CYC);
endmodule

bind pfifo_host_ctrl pfh_checker #(
  .DW(DW), .STROBE_CYC(STROBE_CYC), .SETUP_CYC(SETUP_CYC), .GAP_CYC(GAP_CYC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_n     (rd_n),
  .wr_n     (wr_n),
  .bus_oe   (bus_oe),
  .bus_dout (bus_dout),
  .rx_valid (rx_valid),
  .rx_ready (rx_ready),
  .rx_data  (rx_data),
  .tx_ready (tx_ready)
);

// File: tb/pfifo_host_ctrl_tb.sv
`timescale 1ns/1ps
module pfifo_host_ctrl_tb;
  localparam int DW = 8, STB = 3, SET = 2, GAP = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_valid = 1'b0, rx_ready = 1'b0;
  logic [DW-1:0] tx_data = '0, bus_din = '0;
  logic dav_n = 1'b1, spc_n = 1'b1;
  logic tx_ready, rx_valid, bus_oe, rd_n, wr_n;
  logic [DW-1:0] rx_data, bus_dout;

  always #2 clk = ~clk;  // 250 MHz

  pfifo_host_ctrl #(.DW(DW), .STROBE_CYC(STB), .SETUP_CYC(SET), .GAP_CYC(GAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .bus_din(bus_din),
    .bus_dout(bus_dout), .bus_oe(bus_oe), .rd_n(rd_n), .wr_n(wr_n),
    .dav_n(dav_n), .spc_n(spc_n));

  int checks = 0, errors = 0;
  logic [DW-1:0] dev_src[$];   // bytes the device model will hand out
  logic [DW-1:0] exp_rx[$];    // scoreboard: receive stream
  logic [DW-1:0] exp_tx[$];    // scoreboard: transmit stream
  int rd_falls = 0, wr_falls = 0;
  bit  finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // device model: read strobe fall pops the next byte onto the bus
  always @(negedge rd_n) begin
    rd_falls++;
    chk(dev_src.size() > 0, "R2 read with no byte waiting", 0, 1);
    if (dev_src.size() > 0) bus_din = dev_src.pop_front();
    dav_n = (dev_src.size() == 0);
  end

  // device model: write strobe fall takes the bus byte
  always @(negedge wr_n) begin
    logic [DW-1:0] e;
    wr_falls++;
    chk(bus_oe == 1'b1, "R4 bus driven at write fall", int'(bus_oe), 1);
    if (exp_tx.size() == 0) chk(0, "R4 unexpected write", int'(bus_dout), -1);
    else begin
      e = exp_tx.pop_front();
      chk(bus_dout == e, "R4 written byte", int'(bus_dout), int'(e));
    end
  end

  // monitor: receive scoreboard and pin timing
  int rd_len = 0, wr_len = 0, set_len = 0, gap_len = 0;
  bit prev_rd = 1, prev_wr = 1, prev_oe = 0, seen_strobe = 0;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (rx_valid && rx_ready) begin
        logic [DW-1:0] e;
        if (exp_rx.size() == 0) chk(0, "R3 unexpected rx byte", int'(rx_data), -1);
        else begin
          e = exp_rx.pop_front();
          chk(rx_data == e, "R3 rx byte order", int'(rx_data), int'(e));
        end
      end
      chk(!(!rd_n && !wr_n) && !(!rd_n && bus_oe), "R7 strobe overlap", {rd_n, wr_n, bus_oe}, 3'b110);
      if (prev_rd && !rd_n && seen_strobe) chk(gap_len >= GAP, "R8 gap before read", gap_len, GAP);
      if (!prev_oe && bus_oe && seen_strobe) chk(gap_len >= GAP, "R8 gap before write", gap_len, GAP);
      if (!prev_rd && rd_n) chk(rd_len == STB, "R2 read strobe width", rd_len, STB);
      if (!prev_wr && wr_n) chk(wr_len == STB && !bus_oe, "R4 write strobe width", wr_len, STB);
      if (prev_wr && !wr_n) chk(set_len == SET, "R4 setup time", set_len, SET);
      rd_len  = !rd_n ? rd_len + 1 : 0;
      wr_len  = !wr_n ? wr_len + 1 : 0;
      set_len = (bus_oe && wr_n) ? set_len + 1 : 0;
      gap_len = (rd_n && wr_n && !bus_oe) ? gap_len + 1 : 0;
      if (!rd_n || !wr_n) seen_strobe = 1;
      prev_rd = rd_n; prev_wr = wr_n; prev_oe = bus_oe;
    end
  end

  task automatic dev_give(input logic [DW-1:0] b);
    dev_src.push_back(b);
    exp_rx.push_back(b);
    dav_n = 1'b0;
  endtask

  task automatic send_byte(input logic [DW-1:0] b);
    exp_tx.push_back(b);
    @(negedge clk);
    tx_valid = 1'b1; tx_data = b;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 20000);
    chk(0, "watchdog expired", 0, 1);
    finished = 1;
    report();
  end

  initial begin
    int r0, w0;
    wait_cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_n && wr_n && !bus_oe && !rx_valid, "R1 reset state",
        {rd_n, wr_n, bus_oe, rx_valid}, 4'b1100);

    // R2: no byte waiting -> no read strobe
    rx_ready = 1'b1;
    wait_cyc(20);
    chk(rd_falls == 0, "R2 no read while dav_n high", rd_falls, 0);

    // R2/R3: burst of reads with sink always ready
    dev_give(8'hA5); dev_give(8'h3C); dev_give(8'h00); dev_give(8'hFF);
    wait_cyc(80);
    chk(exp_rx.size() == 0, "R3 all read bytes delivered", exp_rx.size(), 0);

    // R4: writes with room available
    spc_n = 1'b0;
    send_byte(8'h11); send_byte(8'hE7); send_byte(8'h80); send_byte(8'h01);
    wait_cyc(30);
    chk(exp_tx.size() == 0, "R4 all bytes written", exp_tx.size(), 0);

    // R5: no room -> held byte, no write
    spc_n = 1'b1;
    wait_cyc(4);
    w0 = wr_falls;
    exp_tx.push_back(8'h5A);
    tx_valid = 1'b1; tx_data = 8'h5A;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (tx_ready) chk(0, "R5 tx_ready while no room", 1, 0);
    end
    chk(wr_falls == w0, "R5 no write while spc_n high", wr_falls - w0, 0);
    spc_n = 1'b0;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    wait_cyc(20);
    chk(wr_falls == w0 + 1, "R5 held byte written after room", wr_falls - w0, 1);

    // R3: back-pressure on receive stream
    rx_ready = 1'b0;
    r0 = rd_falls;
    dev_give(8'h42); dev_give(8'h24); dev_give(8'h99);
    wait_cyc(50);
    chk(rd_falls == r0 + 1, "R3 one read while sink stalled", rd_falls - r0, 1);
    chk(rx_valid && rx_data == 8'h42, "R3 held byte", int'(rx_data), 8'h42);
    rx_ready = 1'b1;
    wait_cyc(60);
    chk(exp_rx.size() == 0, "R3 stalled bytes delivered", exp_rx.size(), 0);

    // R6: read and write permitted together -> read first
    spc_n = 1'b1;
    wait_cyc(5);
    r0 = rd_falls; w0 = wr_falls;
    exp_tx.push_back(8'hC3);
    tx_valid = 1'b1; tx_data = 8'hC3;
    wait_cyc(5);
    dev_give(8'h6E);
    spc_n = 1'b0;
    while (rd_falls == r0 && wr_falls == w0) @(negedge clk);
    chk(rd_falls == r0 + 1 && wr_falls == w0, "R6 read issued first", rd_falls - r0, 1);
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    wait_cyc(30);
    chk(exp_tx.size() == 0 && exp_rx.size() == 0, "R6 both transfers done",
        exp_tx.size() + exp_rx.size(), 0);

    // R7/R8: interleaved traffic
    for (int k = 0; k < 4; k++) dev_give(8'(8'h10 + k));
    send_byte(8'h77); send_byte(8'h88);
    wait_cyc(80);
    chk(exp_tx.size() == 0 && exp_rx.size() == 0, "R8 mixed traffic drained",
        exp_tx.size() + exp_rx.size(), 0);

    finished = 1;
    report();
  end
endmodule